// File: doc/BRIEF.md
# Serial Port with Two-Character Receive Queue

This block is an asynchronous serial transmitter and receiver. Software reaches it through a small synchronous register bus with an address, a write strobe, a read strobe and a data byte in each direction. Characters are 7 or 8 bits long, least significant bit first. Parity is optional and can be odd or even, and a frame ends with one or two stop bits. Each bit lasts sixteen pulses of the single-cycle `baud_tick` input. The receiver uses the same pulses to oversample the line.

Outgoing characters pass through a one-byte holding register into the shifter. Incoming characters go into a two-entry queue that is read oldest-first, and each read of the receive data register removes one entry. The status register shows ready and second-byte flags for the queue, plus three sticky error flags. Software clears an error flag by writing 1 to its bit. Three interrupt outputs are each gated by their own enable. The receive interrupt can be set to fire at one held byte or at two.

**Transmit machine.** The states are `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_PAR` and `TX_STOP1`/`TX_STOP2`.
- idle → start: the holding register is full and the port is enabled.
- start → data: after 16 ticks.
- data → parity or stop1: after the last data bit. Parity is taken only when enabled.
- parity → stop1.
- stop1 → stop2 or idle: to stop2 when two stop bits are selected, otherwise to idle.
- stop2 → idle.
- Clearing the enable sends any state to idle.

**Receive machine.** The states are `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_PAR` and `RX_STOP`.
- idle → start: a tick finds the line low.
- start → data or idle: the line is checked at mid-bit (8th tick). Low goes to data; high is a false start and returns to idle.
- data → parity or stop: every 16 ticks one bit is sampled. After the last data bit the machine goes to parity when enabled, otherwise to stop.
- parity → stop.
- stop → idle: the first stop bit is sampled and the character is delivered.
- Clearing the enable sends any state to idle.

Top module: `sio_dualrx`

**Register map.** The address is 3 bits wide.

| Address | Register | Bits |
|---|---|---|
| 0 | status | bit0 transmit holding empty, bit1 receive ready, bit2 transmit busy, bit3 second byte held, bit4 overrun, bit5 parity error, bit6 framing error, bit7 zero |
| 1 | transmit data | write only, reads 0 |
| 2 | receive data | read pops one entry |
| 3 | mode | bit0 8-bit length, bit1 parity enable, bit2 odd parity, bit3 two stop bits, bit4 clock-source select (stored only) |
| 4 | control | bit0 enable, bit1 two-byte receive threshold, bit2 transmit-empty interrupt enable, bit3 receive interrupt enable, bit4 error interrupt enable |

## Requirements
- R1: After reset, status reads 0x01, mode and control read 0x00, `ser_txd` is high, and all interrupt outputs are low.
- R2: A transmitted frame has the following layout, with every bit lasting 16 ticks:
  - a low start bit;
  - 8 data bits when mode bit0 = 1, or 7 when it is 0, least significant bit first;
  - a parity bit when mode bit1 = 1, making the count of ones even, or odd when mode bit2 = 1;
  - one high stop bit, or two when mode bit3 = 1.
- R3: Status bit0 reads 1 while the transmit holding register is empty, and status bit2 reads 1 while a frame is being shifted. A write to address 1 while the holding register is full is ignored, and only the earlier characters are sent.
- R4: A received character is stored and status bit1 is set. A read of address 2 returns the oldest character and removes it. Reading an empty queue returns 0.
- R5: Two characters can be held at once; status bit3 reads 1 exactly when two are held. Reads return them in arrival order.
- R6: A character that completes while two are held is discarded, the held characters are kept, and status bit4 is set.
- R7: Status bit5 is set when the received parity does not match the selected mode; the character is still stored. Status bit6 is set when the first stop bit samples low.
- R8: Status bits 4 to 6 stay set until 1 is written to the same bit of address 0. Writing 0 to them has no effect.
- R9: In 7-bit mode bit 6 is the most significant bit of a character, and bit 7 of the receive data reads 0.
- R10: The interrupt outputs are gated by control bits:
  - `irq_txe` = control bit2 AND status bit0;
  - `irq_rxf` = control bit3 AND (two held when control bit1 = 1, else at least one held);
  - `irq_err` = control bit4 AND any error flag.
- R11: While control bit0 = 0, the holding register is not moved to the shifter, `ser_txd` stays high and the receiver ignores the line. Once enabled, a waiting character is sent.
- R12: Reserved bits read 0: mode and control bits 7:5, status bit7, address 1, and addresses 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; pops the queue when it addresses the receive data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| baud_tick | input | 1 | Single-cycle pulse at 16 times the bit rate |
| ser_rxd | input | 1 | Serial receive line, idle high |
| ser_txd | output | 1 | Serial transmit line, idle high |
| irq_txe | output | 1 | Transmit holding empty interrupt |
| irq_rxf | output | 1 | Receive threshold interrupt |
| irq_err | output | 1 | Receive error interrupt |

## Verification
The assertions assume that `baud_tick` is a one-cycle pulse and that `ser_rxd` changes slowly compared to the clock. Both matter: the mid-bit sampling and the once-per-frame delivery of a character depend on them. The bench pulses the tick every fourth clock and holds each bit it drives on the line for exactly 64 clocks. It also gives the bus strobes one cycle each and changes inputs only on the falling clock edge. This way no receive sample lands near a line transition.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } frame_cfg_t;

    localparam int A_STAT = 0;
    localparam int A_TXD  = 1;
    localparam int A_RXD  = 2;
    localparam int A_MODE = 3;
    localparam int A_CTRL = 4;

endpackage

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  frame_cfg_t    cfg,
    input  logic          load,
    input  logic [DW-1:0] ldata,
    output logic          take,
    output logic          busy,
    output logic          txd
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW);

    tx_state_e      state_q, state_d;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  bitn;
    logic [DW-1:0]  sh;
    logic           par;
    logic           bit_end, last_bit;
    logic [DW-1:0]  masked;

    assign bit_end  = tick && (cnt == CW'(OVS-1));
    assign last_bit = bitn == (cfg.len8 ? BW'(DW-1) : BW'(DW-2));
    assign masked   = cfg.len8 ? ldata : {1'b0, ldata[DW-2:0]};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && last_bit) state_d = cfg.par_en ? TX_PAR : TX_STOP1;
            TX_PAR:   if (bit_end) state_d = TX_STOP1;
            TX_STOP1: if (bit_end) state_d = cfg.stop2 ? TX_STOP2 : TX_IDLE;
            TX_STOP2: if (bit_end) state_d = TX_IDLE;
        endcase
        if (!en) state_d = TX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            par  <= 1'b0;
        end else begin
            if (state_q == TX_IDLE) cnt <= '0;
            else if (tick)          cnt <= (cnt == CW'(OVS-1)) ? '0 : cnt + 1'b1;
            if (take) begin
                sh   <= masked;
                bitn <= '0;
                par  <= cfg.par_odd ^ (^masked);
            end else if (state_q == TX_DATA && bit_end) begin
                sh   <= sh >> 1;
                bitn <= bitn + 1'b1;
            end
        end
    end

    always_comb begin
        take = (state_q == TX_IDLE) && (state_d == TX_START);
        busy = (state_q != TX_IDLE);
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_PAR:   txd = par;
            default:  txd = 1'b1;
        endcase
    end

    // R11
    disabled_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> txd);

    // R2
    start_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  frame_cfg_t    cfg,
    input  logic          rxd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW);

    rx_state_e      state_q, state_d;
    logic           s1, s2;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  bitn;
    logic [DW-1:0]  sh;
    logic           pacc;
    logic           mid, full, last_bit;

    assign mid      = tick && (cnt == CW'(OVS/2-1));
    assign full     = tick && (cnt == CW'(OVS-1));
    assign last_bit = bitn == (cfg.len8 ? BW'(DW-1) : BW'(DW-2));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick && !s2) state_d = RX_START;
            RX_START: if (mid) state_d = s2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (full && last_bit) state_d = cfg.par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (full) state_d = RX_STOP;
            RX_STOP:  if (full) state_d = RX_IDLE;
        endcase
        if (!en) state_d = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1;
            cnt <= '0; bitn <= '0; sh <= '0; pacc <= 1'b0;
            done <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
        end else begin
            s1   <= rxd;
            s2   <= s1;
            done <= 1'b0;
            if (state_q != state_d)  cnt <= '0;
            else if (tick)           cnt <= (cnt == CW'(OVS-1)) ? '0 : cnt + 1'b1;
            if (state_q == RX_START) begin
                bitn <= '0;
                pacc <= 1'b0;
            end
            if (full && (state_q == RX_DATA || state_q == RX_PAR)) pacc <= pacc ^ s2;
            if (full && state_q == RX_DATA) begin
                sh   <= {s2, sh[DW-1:1]};
                bitn <= bitn + 1'b1;
            end
            if (full && state_q == RX_STOP) begin
                done <= 1'b1;
                ferr <= !s2;
                perr <= cfg.par_en && (pacc != cfg.par_odd);
            end
        end
    end

    always_comb data = cfg.len8 ? sh : {1'b0, sh[DW-1:1]};

    // R11
    rx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !done);

    // R9
    short_char_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cfg.len8 |-> !data[DW-1]);

endmodule

// File: rtl/sio_dualrx.sv
module sio_dualrx
    import sio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16,
    parameter int AW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          baud_tick,
    input  logic          ser_rxd,
    output logic          ser_txd,
    output logic          irq_txe,
    output logic          irq_rxf,
    output logic          irq_err
);
    localparam int FW = 5;

    logic [FW-1:0] mode_q, ctrl_q;
    frame_cfg_t    cfg;
    logic          en;
    logic [DW-1:0] tx_buf;
    logic          tx_full, tx_take, tx_busy;
    logic          rx_done, rx_perr, rx_ferr;
    logic [DW-1:0] rx_data;
    logic [DW-1:0] e0, e1;
    logic [1:0]    qcnt;
    logic          oe, pe, fe;
    logic          sel_stat, sel_txd, sel_rxd, pop, push;

    assign cfg      = '{len8: mode_q[0], par_en: mode_q[1], par_odd: mode_q[2], stop2: mode_q[3]};
    assign en       = ctrl_q[0];
    assign sel_stat = bus_addr == AW'(A_STAT);
    assign sel_txd  = bus_addr == AW'(A_TXD);
    assign sel_rxd  = bus_addr == AW'(A_RXD);
    assign pop      = bus_rd && sel_rxd && (qcnt != 2'd0);
    assign push     = rx_done;

    sio_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(baud_tick), .cfg(cfg),
        .load(tx_full && en), .ldata(tx_buf), .take(tx_take),
        .busy(tx_busy), .txd(ser_txd)
    );

    sio_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(baud_tick), .cfg(cfg),
        .rxd(ser_rxd), .done(rx_done), .data(rx_data),
        .perr(rx_perr), .ferr(rx_ferr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0; ctrl_q <= '0;
            tx_buf <= '0; tx_full <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == AW'(A_MODE)) mode_q <= bus_wdata[FW-1:0];
            if (bus_wr && bus_addr == AW'(A_CTRL)) ctrl_q <= bus_wdata[FW-1:0];
            if (tx_take) tx_full <= 1'b0;
            else if (bus_wr && sel_txd && !tx_full) begin
                tx_buf  <= bus_wdata;
                tx_full <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e0 <= '0; e1 <= '0; qcnt <= '0;
            oe <= 1'b0; pe <= 1'b0; fe <= 1'b0;
        end else begin
            if (push && pop) begin
                if (qcnt == 2'd1) e0 <= rx_data;
                else begin e0 <= e1; e1 <= rx_data; end
            end else if (pop) begin
                e0   <= e1;
                qcnt <= qcnt - 1'b1;
            end else if (push && qcnt != 2'd2) begin
                if (qcnt == 2'd0) e0 <= rx_data;
                else              e1 <= rx_data;
                qcnt <= qcnt + 1'b1;
            end
            oe <= (oe && !(bus_wr && sel_stat && bus_wdata[4])) || (push && !pop && qcnt == 2'd2);
            pe <= (pe && !(bus_wr && sel_stat && bus_wdata[5])) || (push && rx_perr);
            fe <= (fe && !(bus_wr && sel_stat && bus_wdata[6])) || (push && rx_ferr);
        end
    end

    always_comb begin
        unique case (bus_addr)
            AW'(A_STAT): bus_rdata = {1'b0, fe, pe, oe, qcnt == 2'd2, tx_busy, qcnt != 2'd0, !tx_full};
            AW'(A_RXD):  bus_rdata = (qcnt != 2'd0) ? e0 : '0;
            AW'(A_MODE): bus_rdata = {{(DW-FW){1'b0}}, mode_q};
            AW'(A_CTRL): bus_rdata = {{(DW-FW){1'b0}}, ctrl_q};
            default:     bus_rdata = '0;
        endcase
        irq_txe = ctrl_q[2] && !tx_full;
        irq_rxf = ctrl_q[3] && (ctrl_q[1] ? qcnt == 2'd2 : qcnt != 2'd0);
        irq_err = ctrl_q[4] && (oe || pe || fe);
    end

    // R5
    queue_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qcnt <= 2'd2);

    // R6
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && qcnt == 2'd2 |=> $stable(e0) && $stable(e1) && oe);

    // R8
    sticky_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe && !(bus_wr && sel_stat && bus_wdata[4]) |=> oe);

    // R3
    tx_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && sel_txd && tx_full && !tx_take |=> $stable(tx_buf) && tx_full);

endmodule

// File: tb/sio_dualrx_bench.sv
module sio_dualrx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       baud_tick = 1'b0;
    logic       ser_rxd = 1'b1;
    logic       ser_txd, irq_txe, irq_rxf, irq_err;
    int         checks = 0, errors = 0;
    int         tcnt = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tcnt      <= (tcnt == 3) ? 0 : tcnt + 1;
        baud_tick <= (tcnt == 3);
    end

    sio_dualrx u_sio_dualrx (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .baud_tick(baud_tick), .ser_rxd(ser_rxd), .ser_txd(ser_txd),
        .irq_txe(irq_txe), .irq_rxf(irq_rxf), .irq_err(irq_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(v == e, req, v, e);
    endtask

    task automatic send_rx(input logic [7:0] d, input int nb, input bit pen,
                           input bit pbit, input bit stop);
        @(negedge clk);
        ser_rxd = 1'b0;
        repeat (64) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            ser_rxd = d[i];
            repeat (64) @(negedge clk);
        end
        if (pen) begin
            ser_rxd = pbit;
            repeat (64) @(negedge clk);
        end
        ser_rxd = stop;
        repeat (64) @(negedge clk);
        ser_rxd = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic capture(input int nb, input bit pen, input bit two,
                           output logic [7:0] d, output bit p, output bit s1, output bit s2);
        d = '0; p = 1'b0; s2 = 1'b1;
        wait (ser_txd == 1'b0);
        repeat (32) @(posedge clk);
        for (int i = 0; i < nb; i++) begin
            repeat (64) @(posedge clk);
            d[i] = ser_txd;
        end
        if (pen) begin
            repeat (64) @(posedge clk);
            p = ser_txd;
        end
        repeat (64) @(posedge clk);
        s1 = ser_txd;
        if (two) begin
            repeat (64) @(posedge clk);
            s2 = ser_txd;
        end
    endtask

    task automatic t_reset;
        chk(ser_txd == 1'b1, "R1 txd idle", ser_txd, 1);
        chk({irq_txe, irq_rxf, irq_err} == 3'b000, "R1 irqs", {irq_txe, irq_rxf, irq_err}, 0);
        expect_reg(3'd0, 8'h01, "R1 status");
        expect_reg(3'd3, 8'h00, "R1 mode");
        expect_reg(3'd4, 8'h00, "R1 control");
    endtask

    task automatic t_disabled;
        logic [7:0] d; bit p, s1, s2; int lows = 0;
        wr(3'd3, 8'h01);
        wr(3'd1, 8'h96);
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (!ser_txd) lows++;
        end
        chk(lows == 0, "R11 txd held high while disabled", lows, 0);
        expect_reg(3'd0, 8'h00, "R11 char waits in holding register");
        send_rx(8'h5A, 8, 0, 0, 1);
        expect_reg(3'd0, 8'h00, "R11 receiver ignores line");
        wr(3'd4, 8'h01);
        capture(8, 0, 0, d, p, s1, s2);
        chk(d == 8'h96, "R11 R2 waiting char sent 8N1", d, 8'h96);
        chk(s1 == 1'b1, "R2 stop bit high", s1, 1);
    endtask

    task automatic t_tx_7e2;
        logic [7:0] d, st; bit p, s1, s2;
        wr(3'd3, 8'h0A);
        wr(3'd1, 8'hDA);
        repeat (100) @(negedge clk);
        rd(3'd0, st);
        chk(st[2] == 1'b1, "R3 busy during frame", st[2], 1);
        chk(st[0] == 1'b1, "R3 holding empty after load", st[0], 1);
        capture(7, 1, 1, d, p, s1, s2);
        chk(d == 8'h5A, "R2 7-bit data", d, 8'h5A);
        chk(p == 1'b0, "R2 even parity bit", p, 0);
        chk(s1 && s2, "R2 two stop bits", {s1, s2}, 2'b11);
    endtask

    task automatic t_tx_full;
        logic [7:0] d; bit p, s1, s2; int lows = 0;
        wr(3'd3, 8'h01);
        repeat (200) @(negedge clk);
        wr(3'd1, 8'h11);
        wr(3'd1, 8'h22);
        wr(3'd1, 8'h33);
        expect_reg(3'd0, 8'h04, "R3 holding full and busy");
        capture(8, 0, 0, d, p, s1, s2);
        chk(d == 8'h11, "R3 first char", d, 8'h11);
        capture(8, 0, 0, d, p, s1, s2);
        chk(d == 8'h22, "R3 second char", d, 8'h22);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!ser_txd) lows++;
        end
        chk(lows == 0, "R3 third write ignored", lows, 0);
        expect_reg(3'd0, 8'h01, "R3 idle and empty");
        wr(3'd4, 8'h05);
        @(negedge clk);
        chk(irq_txe == 1'b1, "R10 transmit empty irq", irq_txe, 1);
    endtask

    task automatic t_rx_single;
        wr(3'd4, 8'h01);
        send_rx(8'h3C, 8, 0, 0, 1);
        expect_reg(3'd0, 8'h03, "R4 ready flag");
        expect_reg(3'd2, 8'h3C, "R4 data");
        expect_reg(3'd0, 8'h01, "R4 ready cleared by read");
        expect_reg(3'd2, 8'h00, "R4 empty read");
    endtask

    task automatic t_rx_two;
        wr(3'd4, 8'h0B);
        send_rx(8'hA1, 8, 0, 0, 1);
        chk(irq_rxf == 1'b0, "R10 two-byte threshold not met", irq_rxf, 0);
        expect_reg(3'd0, 8'h03, "R5 one held");
        send_rx(8'h5E, 8, 0, 0, 1);
        expect_reg(3'd0, 8'h0B, "R5 second byte flag");
        chk(irq_rxf == 1'b1, "R10 two-byte threshold met", irq_rxf, 1);
        expect_reg(3'd2, 8'hA1, "R5 oldest first");
        chk(irq_rxf == 1'b0, "R10 below threshold after read", irq_rxf, 0);
        expect_reg(3'd2, 8'h5E, "R5 newer second");
        wr(3'd4, 8'h09);
        send_rx(8'h77, 8, 0, 0, 1);
        chk(irq_rxf == 1'b1, "R10 one-byte threshold", irq_rxf, 1);
        expect_reg(3'd2, 8'h77, "R4 data");
    endtask

    task automatic t_overrun;
        wr(3'd4, 8'h01);
        send_rx(8'h01, 8, 0, 0, 1);
        send_rx(8'h02, 8, 0, 0, 1);
        send_rx(8'h03, 8, 0, 0, 1);
        expect_reg(3'd0, 8'h1B, "R6 overrun flag");
        wr(3'd0, 8'h00);
        expect_reg(3'd0, 8'h1B, "R8 writing 0 keeps flag");
        wr(3'd0, 8'h10);
        expect_reg(3'd0, 8'h0B, "R8 write 1 clears overrun");
        expect_reg(3'd2, 8'h01, "R6 first kept");
        expect_reg(3'd2, 8'h02, "R6 second kept");
        expect_reg(3'd0, 8'h01, "R6 third discarded");
    endtask

    task automatic t_parity;
        wr(3'd3, 8'h06);
        wr(3'd4, 8'h11);
        send_rx(8'h35, 7, 1, 1, 1);
        expect_reg(3'd0, 8'h03, "R7 good odd parity");
        expect_reg(3'd2, 8'h35, "R9 7-bit char bit7 zero");
        chk(irq_err == 1'b0, "R10 no error irq", irq_err, 0);
        send_rx(8'h35, 7, 1, 0, 1);
        expect_reg(3'd0, 8'h23, "R7 parity error flag");
        chk(irq_err == 1'b1, "R10 error irq", irq_err, 1);
        expect_reg(3'd2, 8'h35, "R7 char stored despite parity");
        wr(3'd0, 8'h20);
        expect_reg(3'd0, 8'h01, "R8 write 1 clears parity error");
    endtask

    task automatic t_framing;
        wr(3'd3, 8'h01);
        send_rx(8'h4B, 8, 0, 0, 0);
        expect_reg(3'd0, 8'h43, "R7 framing error flag");
        expect_reg(3'd2, 8'h4B, "R7 char with bad stop");
        wr(3'd0, 8'h40);
        expect_reg(3'd0, 8'h01, "R8 write 1 clears framing error");
    endtask

    task automatic t_reserved;
        wr(3'd3, 8'hFF);
        expect_reg(3'd3, 8'h1F, "R12 mode reserved bits");
        wr(3'd4, 8'hFE);
        expect_reg(3'd4, 8'h1E, "R12 control reserved bits");
        expect_reg(3'd1, 8'h00, "R12 transmit data reads 0");
        expect_reg(3'd5, 8'h00, "R12 unused address");
        expect_reg(3'd7, 8'h00, "R12 unused address");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_tx_7e2;
        t_tx_full;
        t_rx_single;
        t_rx_two;
        t_overrun;
        t_parity;
        t_framing;
        t_reserved;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule